// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block gathers the device interrupt requests of a small multiprocessor into one shared request vector and steers them to each CPU through a mask that belongs to that CPU. Devices raise or drop a request by giving its source number on a post or clear port. For every CPU the block forms a masked view of the shared vector. Any set bit in that view drives the CPU's device interrupt line.

Next to the device path, the block keeps two small pending vectors with one bit per CPU. One holds interprocessor interrupts, which are raised and dropped by CPU bitvector. The other holds timer interrupts, which a single tick pulse raises for every CPU at once and which are dropped by CPU bitvector. Each pending bit drives its own output line.

Software reaches the masks and views all the state through a simple register port. A write lands on the next clock edge. Read data is registered, so it is valid in the cycle after the read strobe.

Top module: `irq_router`

## Requirements
- R1: A post with source number n (0 to NUM_SRC-1) sets bit n of the shared request vector on the next edge. The request vector reads back at offset 0x00, and writes to that offset are ignored.
- R2: A clear with source number n resets bit n on the next edge. When a post and a clear name the same source in the same cycle, the bit ends up set.
- R3: Writing offset 0x10+c loads CPU c's mask from the low NUM_SRC data bits on the next edge. The mask reads back at the same offset.
- R4: Offset 0x20+c reads CPU c's masked view, which is the request vector ANDed with CPU c's mask. Writes to these offsets change nothing.
- R5: Output irq_dev_o[c] is high exactly when CPU c's masked view has any bit set.
- R6: ipi_set and ipi_clr are CPU bitvectors that set or reset interprocessor pending bits on the next edge, with set winning on the same bit. The pending vector drives irq_ipi_o and reads at offset 0x30 in its low bits.
- R7: A tmr_tick pulse sets the timer pending bit of every CPU on the next edge. tmr_clr resets the selected bits, and a tick wins over a clear. The vector drives irq_tmr_o and reads at offset 0x31 in its low bits.
- R8: While rst_n is low at a clock edge, the request vector, all masks, both pending vectors and reg_rdata become zero.
- R9: reg_rdata takes the value of the addressed register (as it stands before that edge's updates) on the edge where reg_rd_en is high. It holds its value when reg_rd_en is low. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_post_vld | input | 1 | Post a device request |
| dev_post_idx | input | IDX_W | Source number to post |
| dev_clr_vld | input | 1 | Clear a device request |
| dev_clr_idx | input | IDX_W | Source number to clear |
| ipi_set | input | NUM_CPU | CPUs to raise an interprocessor interrupt on |
| ipi_clr | input | NUM_CPU | CPUs whose interprocessor interrupt is dropped |
| tmr_tick | input | 1 | Timer tick, raises the timer interrupt on all CPUs |
| tmr_clr | input | NUM_CPU | CPUs whose timer interrupt is dropped |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq_dev_o | output | NUM_CPU | Per-CPU device interrupt |
| irq_ipi_o | output | NUM_CPU | Per-CPU interprocessor interrupt |
| irq_tmr_o | output | NUM_CPU | Per-CPU timer interrupt |

## Verification
The bench builds the router with NUM_CPU set to 3 and keeps the default 64 sources. Three CPUs leave the mask and view offsets 0x13 and 0x23 unmapped, so decode slips into the next CPU's slot show up as non-zero reads. Three-bit pending vectors also test the zero extension in the read data. Keeping 64 sources lets posts and clears on numbers 0 and 63 reach both ends of the request vector and of every mask.

// File: rtl/irq_router_pkg.sv
// Package: register offsets and limits shared by the interrupt router.
// Assumes at most 16 CPUs so the mask and view windows do not overlap.
package irq_router_pkg;
    localparam int OFS_RAW       = 'h00;
    localparam int OFS_MASK_BASE = 'h10;
    localparam int OFS_VIEW_BASE = 'h20;
    localparam int OFS_IPI       = 'h30;
    localparam int OFS_TMR       = 'h31;
    localparam int MAX_CPU       = 16;
endpackage

// File: rtl/irq_src_latch.sv
// Shared device request vector. Each bit is set by a numbered post and
// reset by a numbered clear; a post beats a clear on the same bit.
// Assumes synchronous active-low reset.
module irq_src_latch #(
    parameter int NUM_SRC = 64,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_vld,
    input  logic [IDX_W-1:0]   post_idx,
    input  logic               clr_vld,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NUM_SRC-1:0] raw_o
);
    logic [NUM_SRC-1:0] raw_q;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_bit
        // One request bit: post has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                raw_q[s] <= 1'b0;
            else if (post_vld && post_idx == IDX_W'(s))
                raw_q[s] <= 1'b1;
            else if (clr_vld && clr_idx == IDX_W'(s))
                raw_q[s] <= 1'b0;
        end
    end

    assign raw_o = raw_q;

    a_r1_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        post_vld |=> raw_q[$past(post_idx)]);

    a_r2_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld && !(post_vld && post_idx == clr_idx)) |=> !raw_q[$past(clr_idx)]);
endmodule

// File: rtl/irq_pend_vec.sv
// Pending vector with one bit per CPU, set and cleared by bitvector.
// A set beats a clear on the same bit. Used for both IPI and timer state.
module irq_pend_vec #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] pend_o
);
    logic [WIDTH-1:0] pend_q;

    // Clear the selected bits first, then apply the sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= '0;
        else
            pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    a_r6_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((pend_q & $past(set_i)) == $past(set_i)));

    a_r6_r7_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((pend_q & $past(clr_i & ~set_i)) == '0));

    a_r6_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(pend_q));
endmodule

// File: rtl/irq_cpu_slice.sv
// One CPU's share of the router: its mask register, its masked view of
// the shared request vector, and the OR-reduced device interrupt line.
module irq_cpu_slice #(
    parameter int NUM_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_we,
    input  logic [NUM_SRC-1:0] mask_wdata,
    input  logic [NUM_SRC-1:0] raw_i,
    output logic [NUM_SRC-1:0] mask_o,
    output logic [NUM_SRC-1:0] view_o,
    output logic               dev_irq_o
);
    logic [NUM_SRC-1:0] mask_q;

    // Mask register, loaded by a register-port write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we)
            mask_q <= mask_wdata;
    end

    // Masked view and its reduction to a single line.
    always_comb begin
        view_o    = raw_i & mask_q;
        dev_irq_o = |view_o;
    end

    assign mask_o = mask_q;

    a_r3_mask_loads: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_q == $past(mask_wdata)));

    a_r3_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_q));
endmodule

// File: rtl/irq_router.sv
// Multi-CPU device interrupt router. Owns the register decode and the
// registered read mux; the request vector, per-CPU slices and pending
// vectors live in submodules. Assumes NUM_SRC <= DATA_W and
// NUM_CPU <= 16. Synchronous active-low reset.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int NUM_SRC = 64,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 64,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dev_post_vld,
    input  logic [IDX_W-1:0]  dev_post_idx,
    input  logic              dev_clr_vld,
    input  logic [IDX_W-1:0]  dev_clr_idx,
    input  logic [NUM_CPU-1:0] ipi_set,
    input  logic [NUM_CPU-1:0] ipi_clr,
    input  logic              tmr_tick,
    input  logic [NUM_CPU-1:0] tmr_clr,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NUM_CPU-1:0] irq_dev_o,
    output logic [NUM_CPU-1:0] irq_ipi_o,
    output logic [NUM_CPU-1:0] irq_tmr_o
);
    logic [NUM_SRC-1:0] raw_w;
    logic [NUM_SRC-1:0] mask_w [NUM_CPU];
    logic [NUM_SRC-1:0] view_w [NUM_CPU];
    logic [NUM_CPU-1:0] mask_we_w;
    logic [NUM_CPU-1:0] ipi_w;
    logic [NUM_CPU-1:0] tmr_w;
    logic [DATA_W-1:0]  rd_mux;

    irq_src_latch #(.NUM_SRC(NUM_SRC)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .post_vld (dev_post_vld),
        .post_idx (dev_post_idx),
        .clr_vld  (dev_clr_vld),
        .clr_idx  (dev_clr_idx),
        .raw_o    (raw_w)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        assign mask_we_w[c] = reg_wr_en && reg_addr == ADDR_W'(OFS_MASK_BASE + c);

        irq_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .mask_we    (mask_we_w[c]),
            .mask_wdata (reg_wdata[NUM_SRC-1:0]),
            .raw_i      (raw_w),
            .mask_o     (mask_w[c]),
            .view_o     (view_w[c]),
            .dev_irq_o  (irq_dev_o[c])
        );
    end

    irq_pend_vec #(.WIDTH(NUM_CPU)) u_ipi (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ipi_set),
        .clr_i  (ipi_clr),
        .pend_o (ipi_w)
    );

    irq_pend_vec #(.WIDTH(NUM_CPU)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({NUM_CPU{tmr_tick}}),
        .clr_i  (tmr_clr),
        .pend_o (tmr_w)
    );

    assign irq_ipi_o = ipi_w;
    assign irq_tmr_o = tmr_w;

    // Read decode: select the addressed register, zero for unmapped offsets.
    always_comb begin
        rd_mux = '0;
        if (reg_addr == ADDR_W'(OFS_RAW))
            rd_mux = DATA_W'(raw_w);
        if (reg_addr == ADDR_W'(OFS_IPI))
            rd_mux = DATA_W'(ipi_w);
        if (reg_addr == ADDR_W'(OFS_TMR))
            rd_mux = DATA_W'(tmr_w);
        for (int c = 0; c < NUM_CPU; c++) begin
            if (reg_addr == ADDR_W'(OFS_MASK_BASE + c))
                rd_mux = DATA_W'(mask_w[c]);
            if (reg_addr == ADDR_W'(OFS_VIEW_BASE + c))
                rd_mux = DATA_W'(view_w[c]);
        end
    end

    // Read data register, captured only on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd_en)
            reg_rdata <= rd_mux;
    end

    a_r9_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> $stable(reg_rdata));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && reg_addr == ADDR_W'('h3F)) |=> (reg_rdata == '0));
endmodule

// File: tb/irq_router_tb.sv
// Bench: random stimulus with a fixed seed plus directed corners, checked
// against a behavioural model kept in bench variables.
module irq_router_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCPU  = 3;
    localparam int NSRC  = 64;
    localparam int AW    = 8;
    localparam int DW    = 64;
    localparam int IW    = $clog2(NSRC);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dev_post_vld = 1'b0;
    logic [IW-1:0] dev_post_idx = '0;
    logic dev_clr_vld = 1'b0;
    logic [IW-1:0] dev_clr_idx = '0;
    logic [NCPU-1:0] ipi_set = '0, ipi_clr = '0, tmr_clr = '0;
    logic tmr_tick = 1'b0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic [NCPU-1:0] irq_dev_o, irq_ipi_o, irq_tmr_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [NSRC-1:0] m_raw;
    logic [NSRC-1:0] m_mask [NCPU];
    logic [NCPU-1:0] m_ipi, m_tmr;
    logic [DW-1:0]   m_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_router #(.NUM_CPU(NCPU), .NUM_SRC(NSRC), .ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dev_post_vld(dev_post_vld), .dev_post_idx(dev_post_idx),
        .dev_clr_vld(dev_clr_vld), .dev_clr_idx(dev_clr_idx),
        .ipi_set(ipi_set), .ipi_clr(ipi_clr),
        .tmr_tick(tmr_tick), .tmr_clr(tmr_clr),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_dev_o(irq_dev_o), .irq_ipi_o(irq_ipi_o), .irq_tmr_o(irq_tmr_o)
    );

    // Expected read value from the model (R1, R3, R4, R6, R7, R9 offsets).
    function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
        logic [DW-1:0] v = '0;
        if (a == 8'h00) v = DW'(m_raw);
        if (a == 8'h30) v = DW'(m_ipi);
        if (a == 8'h31) v = DW'(m_tmr);
        for (int c = 0; c < NCPU; c++) begin
            if (a == AW'(8'h10 + c)) v = DW'(m_mask[c]);
            if (a == AW'(8'h20 + c)) v = DW'(m_raw & m_mask[c]);
        end
        return v;
    endfunction

    function automatic logic [NCPU-1:0] exp_dev();
        logic [NCPU-1:0] d;
        for (int c = 0; c < NCPU; c++) d[c] = |(m_raw & m_mask[c]);
        return d;
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_raw = '0; m_ipi = '0; m_tmr = '0; m_rdata = '0;
        for (int c = 0; c < NCPU; c++) m_mask[c] = '0;
    endtask

    // Apply the inputs already driven for one edge, advance the model, compare.
    task automatic step();
        if (reg_rd_en) m_rdata = exp_read(reg_addr);
        if (dev_clr_vld)  m_raw[dev_clr_idx] = 1'b0;
        if (dev_post_vld) m_raw[dev_post_idx] = 1'b1;   // R2: post wins
        for (int c = 0; c < NCPU; c++)
            if (reg_wr_en && reg_addr == AW'(8'h10 + c)) m_mask[c] = reg_wdata[NSRC-1:0];
        m_ipi = (m_ipi & ~ipi_clr) | ipi_set;
        m_tmr = (m_tmr & ~tmr_clr) | {NCPU{tmr_tick}};
        @(posedge clk);
        @(negedge clk);
        chk("R5 irq_dev_o", DW'(irq_dev_o), DW'(exp_dev()));
        chk("R6 irq_ipi_o", DW'(irq_ipi_o), DW'(m_ipi));
        chk("R7 irq_tmr_o", DW'(irq_tmr_o), DW'(m_tmr));
        chk("R9 reg_rdata", reg_rdata, m_rdata);
    endtask

    task automatic idle();
        dev_post_vld = 0; dev_clr_vld = 0; ipi_set = '0; ipi_clr = '0;
        tmr_tick = 0; tmr_clr = '0; reg_wr_en = 0; reg_rd_en = 0;
    endtask

    task automatic rd(input logic [AW-1:0] a);
        idle(); reg_rd_en = 1; reg_addr = a; step(); idle();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        idle(); reg_wr_en = 1; reg_addr = a; reg_wdata = d; step(); idle();
    endtask

    function automatic logic [AW-1:0] rand_addr();
        int k = $urandom_range(0, 9);
        case (k)
            0: return 8'h00;
            1, 2: return AW'(8'h10 + $urandom_range(0, NCPU - 1));
            3, 4: return AW'(8'h20 + $urandom_range(0, NCPU - 1));
            5: return 8'h30;
            6: return 8'h31;
            7: return 8'h13;
            8: return 8'h23;
            default: return 8'h3F;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        model_reset();
        // R8: drive activity during reset; everything must stay zero.
        dev_post_vld = 1; dev_post_idx = 6'd5; ipi_set = '1; tmr_tick = 1;
        reg_wr_en = 1; reg_addr = 8'h10; reg_wdata = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 irq_dev_o in reset", DW'(irq_dev_o), '0);
        chk("R8 irq_ipi_o in reset", DW'(irq_ipi_o), '0);
        chk("R8 irq_tmr_o in reset", DW'(irq_tmr_o), '0);
        chk("R8 reg_rdata in reset", reg_rdata, '0);
        idle();
        rst_n = 1;
        @(negedge clk);
        rd(8'h00); rd(8'h10); rd(8'h12); rd(8'h30); rd(8'h31);   // R8 readback

        // R1 boundaries: sources 0 and 63, read raw vector.
        idle(); dev_post_vld = 1; dev_post_idx = 6'd0; step();
        idle(); dev_post_vld = 1; dev_post_idx = 6'd63; step();
        rd(8'h00);
        // R1: writes to the raw offset are ignored.
        wr(8'h00, '0); rd(8'h00);
        // R3, R5: mask CPU 1 onto source 63 only.
        wr(8'h11, 64'h8000_0000_0000_0000); rd(8'h11); rd(8'h21);
        // R4: a write to a view offset changes nothing.
        wr(8'h21, '0); rd(8'h21); rd(8'h11);
        // R2: same-cycle post and clear of source 63, then clear alone.
        idle(); dev_post_vld = 1; dev_post_idx = 6'd63;
        dev_clr_vld = 1; dev_clr_idx = 6'd63; step();
        rd(8'h00);
        idle(); dev_clr_vld = 1; dev_clr_idx = 6'd63; step();
        rd(8'h21);
        // R6: set and clear same bit, set wins; then clear alone.
        idle(); ipi_set = 3'b010; ipi_clr = 3'b010; step();
        idle(); ipi_clr = 3'b010; step();
        // R7: tick beats clear; then clear two bits.
        idle(); tmr_tick = 1; tmr_clr = 3'b111; step();
        idle(); tmr_clr = 3'b101; step(); rd(8'h31);
        // R9: unmapped offsets read zero, data holds without a read.
        rd(8'h13); rd(8'h23); rd(8'h3F);
        rd(8'h31); idle(); step(); step();

        // Random mix.
        for (int i = 0; i < 4000; i++) begin
            idle();
            dev_post_vld = ($urandom_range(0, 3) == 0);
            dev_post_idx = IW'($urandom);
            dev_clr_vld  = ($urandom_range(0, 2) == 0);
            dev_clr_idx  = ($urandom_range(0, 3) == 0) ? dev_post_idx : IW'($urandom);
            ipi_set  = ($urandom_range(0, 3) == 0) ? NCPU'($urandom) : '0;
            ipi_clr  = ($urandom_range(0, 2) == 0) ? NCPU'($urandom) : '0;
            tmr_tick = ($urandom_range(0, 7) == 0);
            tmr_clr  = ($urandom_range(0, 2) == 0) ? NCPU'($urandom) : '0;
            reg_wr_en = ($urandom_range(0, 4) == 0);
            reg_rd_en = ($urandom_range(0, 1) == 0);
            reg_addr  = rand_addr();
            reg_wdata = ($urandom_range(0, 1) == 0) ? {$urandom, $urandom}
                        : (64'd1 << $urandom_range(0, 63));
            step();
        end
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule